// File: doc/BRIEF.md
# Sleep-Aware CPU Clock and Reset Controller

This block sits between the clock sources of a small microcontroller and its CPU core. Each source is a fast internal oscillator, an external clock input or a slow low-power oscillator. The block sees each source as a one-cycle enable strobe on a single system clock. It picks the CPU clock source and divides it by a power of two from 1 to 128, producing a CPU clock enable. A 2-bit selector routes one of four clocks to a clock-out enable.

The block also manages sleep. A sleep request stops the fast oscillator and forces the CPU back to the internal source. A wake event starts an oscillator recovery window that lasts three rising edges of the slow strobe, and the CPU clock enable resumes only after that window ends.

Power-on and watchdog reset requests return every register to its default. Each source leaves its own cause flag, which firmware clears by writing 1. Firmware reaches the registers through a simple write port. Address 0 is the CPU clock setup, address 1 is the clock-out select and address 2 holds the cause flags.

Top module: `slpclk_ctrl`

## Requirements
- R1: While `por_req` is high and after it falls, the controller shows its power-on defaults. The internal source is selected and the divide ratio is 8. The clock-out select is 00. `por_flag` is 1, `wdt_flag` is 0 and `osc_run` is 1.
- R2: A watchdog request without power-on restores the same register defaults, sets `wdt_flag` and clears `por_flag`. Power-on takes priority when both requests are high. The two flags are never set together.
- R3: A write to address 2 clears `por_flag` when data bit 0 is 1 and clears `wdt_flag` when data bit 1 is 1. A 0 in either bit leaves that flag unchanged.
- R4: A write to address 0 sets the CPU source from data bit 0 (0 internal, 1 external) and the divide code from bits [3:1], giving a ratio of 2^code. While running, `cpu_clk_en` is high on every ratio-th strobe of the selected source and never on strobes of the other source.
- R5: The divider count restarts from zero whenever the source or the ratio changes, and on sleep entry. After such a change, the first enable comes on the ratio-th strobe that follows.
- R6: A sleep request while running enters sleep. In sleep `osc_run` is 0, `cpu_clk_en` is 0, and the source select is forced to internal.
- R7: A wake event during sleep raises `osc_run` and starts recovery. Recovery ends on the third rising edge of `slow_tick`, so a strobe held high counts once. `cpu_clk_en` stays 0 until the cycle after that edge.
- R8: A sleep request made during recovery is ignored, and recovery completes as if it had not come.
- R9: After wake-up the CPU runs from the internal source. External strobes give no enable until firmware writes the source bit to 1 again.
- R10: A write to address 1 sets the clock-out select from data bits [1:0]. `clkout_en` follows `fast_tick` gated by `osc_run` for 00, `ext_tick` for 01, `slow_tick` for 10 and `cpu_clk_en` for 11. The select resets to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on reset request, active high, synchronous |
| wdt_req | input | 1 | Watchdog reset request, active high, synchronous |
| fast_tick | input | 1 | Fast internal oscillator strobe |
| ext_tick | input | 1 | External clock strobe |
| slow_tick | input | 1 | Slow low-power oscillator strobe |
| sleep_req | input | 1 | Request to enter sleep |
| wake_evt | input | 1 | Wake-up event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 setup, 1 clock-out, 2 flags) |
| wr_data | input | 8 | Register write data |
| cpu_clk_en | output | 1 | CPU clock enable |
| clkout_en | output | 1 | Selected clock-out enable |
| por_flag | output | 1 | Last reset came from power-on |
| wdt_flag | output | 1 | Last reset came from the watchdog |
| osc_run | output | 1 | Fast oscillator running (low in sleep) |

## Verification
The assertions check four invariants on every cycle. The CPU enable is silent whenever the oscillator is stopped or recovery is in progress, and the divider count never exceeds the current ratio. The cause flags never both read 1. The oscillator only stops after a sleep request and only restarts after a wake event. The bench's scenarios are needed for the ordered and counted behaviour. These cover the exact strobe on which each ratio fires for both sources, and the restart after a source or ratio change. They also cover recovery counting edges rather than high cycles, the sleep request ignored during recovery, the internal source kept after wake, the write-1-to-clear flags and the defaults that each reset source restores.

// File: rtl/slpclk_ctrl.sv
module slpclk_ctrl #(
  parameter int DIV_BITS = 3,
  parameter int WAKE_EDGES = 3,
  parameter logic [DIV_BITS-1:0] POR_DIV = 3
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       wdt_req,
  input  logic       fast_tick,
  input  logic       ext_tick,
  input  logic       slow_tick,
  input  logic       sleep_req,
  input  logic       wake_evt,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       cpu_clk_en,
  output logic       clkout_en,
  output logic       por_flag,
  output logic       wdt_flag,
  output logic       osc_run
);
  localparam int CNT_W = (1 << DIV_BITS) - 1;
  localparam int REC_W = $clog2(WAKE_EDGES + 1);

  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_SLEEP = 2'd1, ST_RECOV = 2'd2} state_t;

  state_t              state;
  logic                src_ext;
  logic [DIV_BITS-1:0] div_code;
  logic [1:0]          clkout_sel;
  logic [CNT_W-1:0]    cnt;
  logic [REC_W-1:0]    rec_cnt;
  logic                slow_q;

  logic [CNT_W:0]      ratio;
  logic [CNT_W-1:0]    ratio_m1;
  logic                src_tick, div_last, slow_rise, go_sleep;
  logic                cfg_wr, sel_wr, flag_wr;
  logic                nx_src, cfg_change;
  logic [DIV_BITS-1:0] nx_div;

  wire unused_wr_data = ^wr_data[7:DIV_BITS+1];

  assign ratio      = (CNT_W+1)'(1) << div_code;
  assign ratio_m1   = ratio[CNT_W-1:0] - CNT_W'(1);
  assign src_tick   = src_ext ? ext_tick : fast_tick;
  assign div_last   = (cnt == ratio_m1);
  assign slow_rise  = slow_tick && !slow_q;
  assign go_sleep   = (state == ST_RUN) && sleep_req;

  assign cfg_wr     = wr_en && (wr_addr == 2'd0);
  assign sel_wr     = wr_en && (wr_addr == 2'd1);
  assign flag_wr    = wr_en && (wr_addr == 2'd2);

  assign nx_src     = go_sleep ? 1'b0 : (cfg_wr ? wr_data[0] : src_ext);
  assign nx_div     = cfg_wr ? wr_data[DIV_BITS:1] : div_code;
  assign cfg_change = (nx_src != src_ext) || (nx_div != div_code);

  assign osc_run    = (state != ST_SLEEP);
  assign cpu_clk_en = (state == ST_RUN) && src_tick && div_last;

  always_comb begin
    case (clkout_sel)
      2'b00:   clkout_en = fast_tick && osc_run;
      2'b01:   clkout_en = ext_tick;
      2'b10:   clkout_en = slow_tick;
      default: clkout_en = cpu_clk_en;
    endcase
  end

  always_ff @(posedge clk) begin
    slow_q <= slow_tick;
    if (por_req || wdt_req) begin
      state      <= ST_RUN;
      src_ext    <= 1'b0;
      div_code   <= POR_DIV;
      clkout_sel <= 2'b00;
      cnt        <= '0;
      rec_cnt    <= '0;
      por_flag   <= por_req;
      wdt_flag   <= !por_req;
    end else begin
      src_ext  <= nx_src;
      div_code <= nx_div;
      if (sel_wr) clkout_sel <= wr_data[1:0];
      if (flag_wr) begin
        por_flag <= por_flag && !wr_data[0];
        wdt_flag <= wdt_flag && !wr_data[1];
      end

      if (cfg_change || go_sleep)
        cnt <= '0;
      else if (state == ST_RUN && src_tick)
        cnt <= div_last ? '0 : cnt + CNT_W'(1);

      case (state)
        ST_RUN:   if (sleep_req) state <= ST_SLEEP;
        ST_SLEEP: if (wake_evt) begin
          state   <= ST_RECOV;
          rec_cnt <= '0;
        end
        ST_RECOV: if (slow_rise) begin
          if (rec_cnt == REC_W'(WAKE_EDGES - 1)) begin
            state   <= ST_RUN;
            rec_cnt <= '0;
          end else begin
            rec_cnt <= rec_cnt + REC_W'(1);
          end
        end
        default:  state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/slpclk_ctrl_chk.sv
module slpclk_ctrl_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             por_req,
  input logic             sleep_req,
  input logic             wake_evt,
  input logic             osc_run,
  input logic             cpu_clk_en,
  input logic             por_flag,
  input logic             wdt_flag,
  input logic [1:0]       state,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] ratio_m1
);
  AST_NO_CLK_ASLEEP: assert property (@(posedge clk) disable iff (por_req) !osc_run |-> !cpu_clk_en); // R6
  AST_NO_CLK_RECOV: assert property (@(posedge clk) disable iff (por_req) (state == 2'd2) |-> !cpu_clk_en); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (por_req) cnt <= ratio_m1); // R4
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (por_req) !(por_flag && wdt_flag)); // R2
  AST_OSC_STOP_CAUSE: assert property (@(posedge clk) disable iff (por_req) $fell(osc_run) |-> $past(sleep_req)); // R6
  AST_OSC_START_CAUSE: assert property (@(posedge clk) disable iff (por_req) (osc_run && !$past(osc_run)) |-> $past(wake_evt)); // R7
endmodule

bind slpclk_ctrl slpclk_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_req(por_req), .sleep_req(sleep_req), .wake_evt(wake_evt),
  .osc_run(osc_run), .cpu_clk_en(cpu_clk_en), .por_flag(por_flag), .wdt_flag(wdt_flag),
  .state(state), .cnt(cnt), .ratio_m1(ratio_m1)
);

// File: tb/slpclk_ctrl_tb_top.sv
`timescale 1ns/1ps
module slpclk_ctrl_tb_top;
  logic clk = 0;
  logic por_req = 1, wdt_req = 0;
  logic fast_tick = 0, ext_tick = 0, slow_tick = 0;
  logic sleep_req = 0, wake_evt = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic cpu_clk_en, clkout_en, por_flag, wdt_flag, osc_run;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  slpclk_ctrl dut_i (
    .clk(clk), .por_req(por_req), .wdt_req(wdt_req),
    .fast_tick(fast_tick), .ext_tick(ext_tick), .slow_tick(slow_tick),
    .sleep_req(sleep_req), .wake_evt(wake_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_clk_en(cpu_clk_en), .clkout_en(clkout_en),
    .por_flag(por_flag), .wdt_flag(wdt_flag), .osc_run(osc_run)
  );

  task automatic chk(input string rq, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%b expected=%b at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic drv(input logic f, input logic e, input logic s,
                     input logic slp = 0, input logic wk = 0);
    @(negedge clk);
    wr_en = 0; fast_tick = f; ext_tick = e; slow_tick = s;
    sleep_req = slp; wake_evt = wk;
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    fast_tick = 0; ext_tick = 0; slow_tick = 0; sleep_req = 0; wake_evt = 0;
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  task automatic div_sweep(input logic src, input int code, input string rq);
    int ratio = 1 << code;
    int n = 0;
    wr(2'd0, 8'((code << 1) | src));
    for (int k = 0; k < 4 * ratio + 4; k++) begin
      logic st = (k % 2 == 0);
      logic ot = !st;
      drv(src ? ot : st, src ? st : ot, 0);
      chk(rq, cpu_clk_en, st && ((n + 1) % ratio == 0));
      if (st) n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 osc_run in reset", osc_run, 1);
    @(negedge clk); por_req = 0;
    #1;
    chk("R1 por_flag", por_flag, 1);
    chk("R1 wdt_flag", wdt_flag, 0);
    chk("R1 osc_run", osc_run, 1);
    drv(1, 0, 0); chk("R1 clkout default fast", clkout_en, 1);
    drv(0, 0, 1); chk("R1 clkout default not slow", clkout_en, 0);
    // R1 default ratio 8: enable on 8th fast strobe (one strobe already spent above)
    for (int k = 2; k <= 16; k++) begin
      drv(1, 0, 0);
      chk("R1 default divide by 8", cpu_clk_en, (k % 8) == 0);
    end

    // R3 write-1-to-clear
    wr(2'd2, 8'b0000_0010); drv(0, 0, 0);
    chk("R3 zero bit keeps por_flag", por_flag, 1);
    wr(2'd2, 8'b0000_0001); drv(0, 0, 0);
    chk("R3 clear por_flag", por_flag, 0);

    // R4 full divider sweep over both sources
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 8; c++)
        div_sweep(s[0], c, s ? "R4 ext source ratio" : "R4 fast source ratio");

    // R10 clock-out select sweep, CPU at ratio 1 on fast source
    wr(2'd0, 8'h00);
    for (int sel = 0; sel < 4; sel++) begin
      wr(2'd1, 8'(sel));
      for (int v = 0; v < 8; v++) begin
        logic f = v[0], e = v[1], s = v[2];
        logic exp;
        drv(f, e, s);
        case (sel)
          0: exp = f;
          1: exp = e;
          2: exp = s;
          default: exp = f;
        endcase
        chk("R10 clkout select", clkout_en, exp);
      end
    end

    // R5 ratio change restarts count
    wr(2'd0, 8'h06);
    for (int k = 0; k < 3; k++) begin drv(1, 0, 0); chk("R5 pre-change", cpu_clk_en, 0); end
    wr(2'd0, 8'h04);
    for (int k = 1; k <= 4; k++) begin drv(1, 0, 0); chk("R5 ratio change restart", cpu_clk_en, k == 4); end
    // R5 source change restarts count
    for (int k = 0; k < 3; k++) begin drv(1, 0, 0); chk("R5 pre-src-change", cpu_clk_en, 0); end
    wr(2'd0, 8'h05);
    for (int k = 1; k <= 4; k++) begin drv(0, 1, 0); chk("R5 source change restart", cpu_clk_en, k == 4); end

    // R6 sleep entry from external source, ratio 1
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h00);
    drv(0, 1, 0); chk("R4 ext ratio 1", cpu_clk_en, 1);
    drv(0, 0, 0, 1);
    drv(1, 1, 0);
    chk("R6 osc stopped", osc_run, 0);
    chk("R6 no cpu clock asleep", cpu_clk_en, 0);
    chk("R6 fast clkout gated asleep", clkout_en, 0);
    drv(1, 1, 1); chk("R6 still asleep without wake", osc_run, 0);

    // R7 recovery on rising edges of slow strobe; R8 sleep during recovery
    drv(0, 0, 0, 0, 1);
    drv(1, 0, 0); chk("R7 osc restarts on wake", osc_run, 1);
    chk("R7 no clock in recovery", cpu_clk_en, 0);
    drv(1, 0, 1); chk("R7 edge 1", cpu_clk_en, 0);
    drv(1, 0, 1); chk("R7 held strobe", cpu_clk_en, 0);
    drv(1, 0, 1); chk("R7 held strobe counts once", cpu_clk_en, 0);
    drv(1, 0, 0); chk("R7 gap", cpu_clk_en, 0);
    drv(1, 0, 1); chk("R7 edge 2", cpu_clk_en, 0);
    drv(1, 0, 0, 1); chk("R8 sleep ignored in recovery", cpu_clk_en, 0);
    drv(1, 0, 0); chk("R8 osc still running", osc_run, 1);
    drv(1, 0, 1); chk("R7 edge 3 cycle", cpu_clk_en, 0);
    drv(1, 0, 0); chk("R7 clock resumes after third edge", cpu_clk_en, 1);
    chk("R8 running after recovery", osc_run, 1);

    // R9 internal source kept after wake
    drv(0, 1, 0); chk("R9 ext ignored after wake", cpu_clk_en, 0);
    drv(1, 0, 0); chk("R9 internal after wake", cpu_clk_en, 1);
    wr(2'd0, 8'h01);
    drv(0, 1, 0); chk("R9 ext after firmware write", cpu_clk_en, 1);
    drv(1, 0, 0); chk("R9 fast ignored on ext", cpu_clk_en, 0);

    // R2 watchdog reset
    wr(2'd1, 8'h02);
    @(negedge clk); wr_en = 0; wdt_req = 1;
    @(negedge clk); wdt_req = 0; #1;
    chk("R2 wdt_flag set", wdt_flag, 1);
    chk("R2 por_flag clear", por_flag, 0);
    drv(1, 0, 0); chk("R2 clkout back to fast", clkout_en, 1);
    for (int k = 2; k <= 8; k++) begin
      drv(1, 1, 0);
      chk("R2 divide by 8 internal restored", cpu_clk_en, k == 8);
    end
    wr(2'd2, 8'h01); drv(0, 0, 0);
    chk("R3 zero bit keeps wdt_flag", wdt_flag, 1);
    wr(2'd2, 8'h02); drv(0, 0, 0);
    chk("R3 clear wdt_flag", wdt_flag, 0);

    // R2 power-on wins over watchdog
    @(negedge clk); wdt_req = 1; por_req = 1;
    @(negedge clk); wdt_req = 0; por_req = 0; #1;
    chk("R2 por priority por_flag", por_flag, 1);
    chk("R2 por priority wdt_flag", wdt_flag, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule